// File: doc/BRIEF.md
# Disarmable Watchdog Timer

This block supervises a piece of work that software expects to finish within a bounded time. Software arms it with an interval expressed in ticks of an external timebase enable. From then on the block counts those ticks downward. If software reports completion by writing a disarm command before the count runs out, the watchdog stops quietly. If the count runs out while the watchdog is still armed, the block raises a sticky timeout interrupt. If reset generation was selected when it was armed, it also drives a system reset pulse of fixed length.

All control goes through a single write-only control word, which carries the command bits and the interval together. The interval and the reset selection are captured only when an arming write is accepted. After a timeout the watchdog falls back to the disarmed state and waits for the next arming write.

Top module: `wdog_disarm`

## Requirements
- R1: While rst_ni is low and after its release, irq_o and sys_rst_o are 0 and the watchdog is disarmed, so ticks cause no timeout until an arming write.
- R2: A control write with bit 0 (arm) set and a nonzero interval N in bits [8 +: CNT_W] arms the watchdog while it is disarmed. irq_o rises in the cycle after the N-th tick_i pulse that follows the arming write.
- R3: Only cycles with tick_i high advance the count. Any number of cycles without a tick leave the expiry point unchanged.
- R4: A control write with bit 1 (disarm) set stops the watchdog with no timeout. This includes a disarm in the same cycle as the tick that would have expired it.
- R5: An arming write while already armed has no effect. It changes neither the remaining count nor the reset selection.
- R6: An arming write with an interval of zero is ignored, and the watchdog stays disarmed.
- R7: irq_o stays high until a control write with bit 3 (clear) set. If a timeout and a clear fall in the same cycle, the timeout wins.
- R8: If bit 2 (reset enable) was set in the accepted arming write, sys_rst_o is high for exactly RST_CYC cycles, starting with the cycle in which irq_o rises. If that bit was clear, sys_rst_o stays low.
- R9: After a timeout the watchdog is disarmed, and further ticks produce no new timeout until it is armed again.
- R10: An arming write in the same cycle as a tick does not count that tick. A write with both arm and disarm set leaves the watchdog disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | CNT_W+8 | Control word: arm, disarm, reset enable, clear, interval |
| tick_i | input | 1 | Timebase enable, one count per high cycle |
| irq_o | output | 1 | Sticky timeout interrupt |
| sys_rst_o | output | 1 | System reset pulse, RST_CYC cycles long |

## Verification
The bench builds the block with CNT_W = 6 and RST_CYC = 3. The narrow counter makes the largest interval, 63 ticks, reachable within a short run. The short pulse lets a second timeout land while an earlier reset pulse is still active or just finished. Random stimulus mixes sparse ticks with writes that carry random command bits and intervals, so arming while armed, zero intervals and disarm-versus-expiry collisions occur many times. Directed sequences pin down each of those collisions at the exact cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ARM_BIT    = 0;
  localparam int unsigned DISARM_BIT = 1;
  localparam int unsigned RSTEN_BIT  = 2;
  localparam int unsigned CLR_BIT    = 3;
  localparam int unsigned IVAL_LSB   = 8;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic rst_en;
    logic irq_clr;
  } wd_cmd_t;
endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                      we_i,
  input  logic [CNT_W+IVAL_LSB-1:0] wdata_i,
  output wd_cmd_t                   cmd_o,
  output logic [CNT_W-1:0]          ival_o
);
  always_comb begin
    cmd_o.arm     = we_i & wdata_i[ARM_BIT];
    cmd_o.disarm  = we_i & wdata_i[DISARM_BIT];
    cmd_o.rst_en  = wdata_i[RSTEN_BIT];
    cmd_o.irq_clr = we_i & wdata_i[CLR_BIT];
    ival_o        = wdata_i[IVAL_LSB +: CNT_W];
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wd_cmd_t          cmd_i,
  input  logic [CNT_W-1:0] ival_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_en_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_en_q;
  logic             accept_arm;

  // disarm outranks everything, including the final tick
  assign expire_o   = armed_q & tick_i & (cnt_q == ONE) & ~cmd_i.disarm;
  assign accept_arm = ~armed_q & cmd_i.arm & (ival_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      rst_en_q <= 1'b0;
    end else if (cmd_i.disarm) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept_arm) begin
      armed_q  <= 1'b1;
      cnt_q    <= ival_i;
      rst_en_q <= cmd_i.rst_en;
    end else if (expire_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign armed_o  = armed_q;
  assign cnt_o    = cnt_q;
  assign rst_en_o = rst_en_q;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned RST_W = $clog2(RST_CYC + 1);

  logic [RST_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= RST_W'(RST_CYC);
    else if (left_q != '0)   left_q <= left_q - RST_W'(1);
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdog_disarm.sv
module wdog_disarm
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_CYC = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ctl_we_i,
  input  logic [CNT_W+IVAL_LSB-1:0] ctl_wdata_i,
  input  logic                      tick_i,
  output logic                      irq_o,
  output logic                      sys_rst_o
);
  wd_cmd_t          cmd;
  logic [CNT_W-1:0] ival;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             rst_en;
  logic             expire;
  logic             irq_q;

  wdog_cmd_dec #(.CNT_W(CNT_W)) i_dec (
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .cmd_o   (cmd),
    .ival_o  (ival)
  );

  wdog_down_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cmd_i    (cmd),
    .ival_i   (ival),
    .armed_o  (armed),
    .cnt_o    (cnt),
    .rst_en_o (rst_en),
    .expire_o (expire)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           irq_q <= 1'b0;
    else if (expire)       irq_q <= 1'b1;
    else if (cmd.irq_clr)  irq_q <= 1'b0;
  end
  assign irq_o = irq_q;

  generate
    if (RST_CYC == 0) begin : g_no_rst
      assign sys_rst_o = 1'b0;
    end else begin : g_rst
      wdog_rst_pulse #(.RST_CYC(RST_CYC)) i_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fire_i  (expire & rst_en),
        .pulse_o (sys_rst_o)
      );
    end
  endgenerate
endmodule

// File: rtl/wdog_disarm_sva.sv
module wdog_disarm_sva
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ctl_we_i,
  input logic [CNT_W+IVAL_LSB-1:0] ctl_wdata_i,
  input logic                      tick_i,
  input logic                      irq_o,
  input logic                      sys_rst_o,
  input logic                      armed,
  input logic [CNT_W-1:0]          cnt,
  input logic                      rst_en,
  input logic                      expire
);
  logic wr_arm, wr_dis, wr_clr;
  assign wr_arm = ctl_we_i & ctl_wdata_i[ARM_BIT];
  assign wr_dis = ctl_we_i & ctl_wdata_i[DISARM_BIT];
  assign wr_clr = ctl_we_i & ctl_wdata_i[CLR_BIT];

  assert_live_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> cnt != '0);

  assert_irq_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire));

  assert_disarm_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> !armed);

  assert_rearm_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && wr_arm && !wr_dis && !tick_i) |=> $stable(cnt) && $stable(rst_en));

  assert_zero_ival_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && wr_arm && ctl_wdata_i[IVAL_LSB +: CNT_W] == '0) |=> !armed);

  assert_sticky_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_clr) |=> irq_o);

  assert_rst_from_expire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(expire && rst_en));

  assert_expire_disarms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !armed);
endmodule

bind wdog_disarm wdog_disarm_sva #(.CNT_W(CNT_W)) i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .tick_i      (tick_i),
  .irq_o       (irq_o),
  .sys_rst_o   (sys_rst_o),
  .armed       (armed),
  .cnt         (cnt),
  .rst_en      (rst_en),
  .expire      (expire)
);

// File: tb/test_wdog_disarm.sv
`timescale 1ns/1ps
module test_wdog_disarm;
  localparam int unsigned CW  = 6;
  localparam int unsigned RC  = 3;
  localparam int unsigned DW  = CW + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          tick = 1'b0;
  logic          irq, srst;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  wdog_disarm #(.CNT_W(CW), .RST_CYC(RC)) i_wdog_disarm (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .tick_i(tick), .irq_o(irq), .sys_rst_o(srst)
  );

  function automatic logic [DW-1:0] mk(bit a, bit d, bit re, bit c, int unsigned iv);
    logic [DW-1:0] v;
    v = '0;
    v[0] = a; v[1] = d; v[2] = re; v[3] = c;
    v[8 +: CW] = CW'(iv);
    return v;
  endfunction

  // reference model built from the requirements
  logic          m_armed, m_ren, m_irq;
  int unsigned   m_cnt, m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed <= 0; m_ren <= 0; m_irq <= 0; m_cnt <= 0; m_left <= 0;
    end else begin
      bit dis, arm, clr, exp_now;
      dis = we && wdata[1];
      arm = we && wdata[0];
      clr = we && wdata[3];
      exp_now = m_armed && tick && m_cnt == 1 && !dis;
      if (dis) m_armed <= 0;
      else if (!m_armed && arm && wdata[8 +: CW] != 0) begin
        m_armed <= 1; m_cnt <= wdata[8 +: CW]; m_ren <= wdata[2];
      end else if (exp_now) m_armed <= 0;
      else if (m_armed && tick) m_cnt <= m_cnt - 1;
      if (exp_now) m_irq <= 1; else if (clr) m_irq <= 0;
      if (exp_now && m_ren) m_left <= RC;
      else if (m_left != 0) m_left <= m_left - 1;
    end
  end

  task automatic check(logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit w, logic [DW-1:0] d);
    @(negedge clk);
    check(irq, m_irq, "irq_o");
    check(srst, m_left != 0, "sys_rst_o");
    tick = t; we = w; wdata = d;
  endtask

  task automatic idle(int n, bit t);
    for (int i = 0; i < n; i++) step(t, 0, '0);
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0007));
    // R1: reset state
    #20;
    compared++;
    if (irq !== 1'b0 || srst !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset outputs: actual %0b%0b expected 00", irq, srst);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(10, 1);

    // R2 + R3: interval 5, ticks spread apart
    cur_req = "R2";
    step(0, 1, mk(1, 0, 0, 0, 5));
    cur_req = "R3";
    for (int i = 0; i < 5; i++) begin step(1, 0, '0); idle(3, 0); end
    idle(3, 0);

    // R7: clear, then set/clear collision
    cur_req = "R7";
    step(0, 1, mk(0, 0, 0, 1, 0));
    idle(2, 0);
    step(0, 1, mk(1, 0, 0, 0, 1));
    step(1, 1, mk(0, 0, 0, 1, 0));
    idle(3, 0);
    step(0, 1, mk(0, 0, 0, 1, 0));

    // R8: reset pulse selected
    cur_req = "R8";
    step(0, 1, mk(1, 0, 1, 0, 3));
    idle(8, 1);
    step(0, 1, mk(0, 0, 0, 1, 0));
    step(0, 1, mk(1, 0, 0, 0, 2));
    idle(8, 1);
    step(0, 1, mk(0, 0, 0, 1, 0));

    // R4: disarm on the expiring tick
    cur_req = "R4";
    step(0, 1, mk(1, 0, 1, 0, 4));
    idle(3, 1);
    step(1, 1, mk(0, 1, 0, 0, 0));
    idle(10, 1);

    // R5: rearm while armed ignored
    cur_req = "R5";
    step(0, 1, mk(1, 0, 0, 0, 2));
    step(1, 1, mk(1, 0, 1, 0, 9));
    idle(12, 1);
    step(0, 1, mk(0, 0, 0, 1, 0));

    // R6: zero interval
    cur_req = "R6";
    step(0, 1, mk(1, 0, 1, 0, 0));
    idle(80, 1);

    // R9: no further timeout after expiry
    cur_req = "R9";
    step(0, 1, mk(1, 0, 0, 0, 1));
    idle(2, 1);
    step(0, 1, mk(0, 0, 0, 1, 0));
    idle(70, 1);

    // R10: arm with tick, arm+disarm together
    cur_req = "R10";
    step(1, 1, mk(1, 0, 0, 0, 2));
    idle(4, 1);
    step(0, 1, mk(0, 0, 0, 1, 0));
    step(1, 1, mk(1, 1, 1, 0, 1));
    idle(5, 1);
    step(0, 1, mk(1, 0, 1, 0, 63));
    idle(66, 1);

    // random mix
    cur_req = "R2/R4/R7/R8";
    for (int i = 0; i < 6000; i++) begin
      bit t, w;
      int unsigned iv;
      t = ($urandom_range(0, 2) == 0);
      w = ($urandom_range(0, 11) == 0);
      iv = ($urandom_range(0, 15) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 6);
      step(t, w, mk($urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, iv));
    end
    idle(5, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule